// File: doc/BRIEF.md
# Serialized Interrupt Slave Agent

This block is the peripheral end of a single-wire serialized interrupt line. It watches the shared line for a Start Frame and then counts three-clock frames. In the frame chosen by a slot number it reports the level of one local interrupt. When the frames are over it measures the width of the closing low pulse. That width decides whether the next cycle may be launched by peripherals (quiet) or only by the host (continuous).

In quiet mode, a change of the local interrupt arms a request. The agent then pulls the line low for one clock to open a new cycle, and the host stretches that pulse into a full Start Frame. The agent only produces an open-drain drive enable and a drive value. The pad, the pull-up and the host side are outside the block.

Top module: `sirq_slave_agent`

## Requirements
- R1: While reset is asserted `driveEn` is 0. After reset the agent is in continuous mode, so a change of `irqLevel` alone causes no drive.
- R2: A Start Frame is a run of 4 to 8 consecutive low samples of `lineIn` followed by a high sample. A low run of 3 or of 9 or more in the idle state starts no frame, and the agent drives nothing.
- R3: The clock in which the line is first high after a valid Start Frame is position 0. Slot k (0 to NUM_FRAMES-1, given on `slotSel`) has its sample clock at position 3k+2, so slot 13 samples at position 41. A `slotSel` of NUM_FRAMES or more never drives.
- R4: In its sample clock the agent drives the line low (`driveEn`=1, `driveVal`=0) when `irqLevel` was 0 at the previous clock edge, and leaves the line released when it was 1.
- R5: In position 3k+3 the agent drives high (`driveEn`=1, `driveVal`=1) for exactly one clock, then releases the line. Low drives never last longer than one clock.
- R6: Once position 3*NUM_FRAMES+1 has passed, a low run of exactly 2 followed by a high sample selects quiet mode, and a run of exactly 3 selects continuous mode. A run of any other width is ignored, and the agent keeps waiting for a valid Stop Frame.
- R7: In quiet mode with a request armed, the agent drives low for one clock. It does so no earlier than the second clock after the Stop Frame's rising edge (the first high clock is clock 0), and only when the line was high at the edge that launches it.
- R8: In continuous mode the agent never launches a Start Frame.
- R9: A request is armed when `irqLevel` differs from its value at the previous edge. The request is cleared when the agent launches a Start Frame or when a Start Frame is recognized. A change seen at the same edge that recognizes a Start Frame leaves the request armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineIn | input | 1 | Sampled level of the shared interrupt line |
| irqLevel | input | 1 | Local interrupt level (1 = asserted) |
| slotSel | input | SLOT_W | Frame slot assigned to this agent |
| driveEn | output | 1 | Open-drain output enable for the line |
| driveVal | output | 1 | Level driven when `driveEn` is 1 |

## Verification
Two functions can meet on one clock edge. The edge that recognizes a Start Frame clears the pending request, and that same edge may also see a new change of the local interrupt that arms the request. The bench sets up this case by changing `irqLevel` in the position-0 clock of a frame sequence. It then closes the cycle with a two-clock Stop Frame and expects a launch pulse at exactly the second clock after the rising edge. A control run changes the level during the Start Frame instead, and must produce no launch.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SELFSTART = 2'd1,
    ST_FRAMES    = 2'd2,
    ST_STOPWAIT  = 2'd3
  } agentState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic posStart;   // load position counter with 1 (position 0 just ended)
    logic posAdv;     // advance position counter
    logic pendClear;  // drop the pending launch request
    logic gapLoad;    // stop frame rising edge seen: restart holdoff count
    logic setQuiet;   // next cycle quiet
    logic setCont;    // next cycle continuous
    logic inFrames;   // frame slots are running
    logic selfStart;  // agent pulls the line low to open a cycle
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic quiet;      // current mode is quiet
    logic pending;    // launch request armed
    logic gapOk;      // line high and at least one high clock since stop
    logic lastPos;    // position counter at last turnaround clock
    logic runStart;   // high sample closing a start-width low run
    logic runStop2;   // high sample closing a two-clock low run
    logic runStop3;   // high sample closing a three-clock low run
  } dpStatus_t;

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   sts,
  output ctlStrobe_t  ctl
);

  agentState_t curState;
  agentState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  always_comb begin
    ctl           = '0;
    nextState     = curState;
    ctl.inFrames  = (curState == ST_FRAMES);
    ctl.selfStart = (curState == ST_SELFSTART);
    case (curState)
      ST_IDLE: begin
        if (sts.runStart) begin
          ctl.posStart  = 1'b1;
          ctl.pendClear = 1'b1;
          nextState     = ST_FRAMES;
        end else if (sts.quiet && sts.pending && sts.gapOk) begin
          ctl.pendClear = 1'b1;
          nextState     = ST_SELFSTART;
        end
      end
      ST_SELFSTART: begin
        nextState = ST_IDLE;
      end
      ST_FRAMES: begin
        ctl.posAdv = 1'b1;
        if (sts.lastPos) nextState = ST_STOPWAIT;
      end
      ST_STOPWAIT: begin
        if (sts.runStop2) begin
          ctl.setQuiet = 1'b1;
          ctl.gapLoad  = 1'b1;
          nextState    = ST_IDLE;
        end else if (sts.runStop3) begin
          ctl.setCont = 1'b1;
          ctl.gapLoad = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 17,
  parameter int SLOT_W     = 5,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              irqLevel,
  input  logic [SLOT_W-1:0] slotSel,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         sts,
  output logic              driveEn,
  output logic              driveVal
);

  localparam int RUN_W     = $clog2(START_MAX + 2);
  localparam int LAST_POS  = 3 * NUM_FRAMES + 1;
  localparam int POS_W     = $clog2(LAST_POS + 2);
  localparam int CMP_W     = ((POS_W > SLOT_W + 2) ? POS_W : SLOT_W + 2) + 1;
  localparam int QUIET_LOW = 2;
  localparam int CONT_LOW  = 3;
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [RUN_W-1:0] lowRun;
  logic [POS_W-1:0] posCnt;
  logic [1:0]       gapCnt;
  logic             irqQ;
  logic             pending;
  logic             quietMode;

  // consecutive low samples, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowRun <= '0;
    else if (lineIn)      lowRun <= '0;
    else if (lowRun != RUN_MAX) lowRun <= lowRun + RUN_W'(1);
  end

  // frame position counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             posCnt <= '0;
    else if (ctl.posStart) posCnt <= POS_W'(1);
    else if (ctl.posAdv)   posCnt <= posCnt + POS_W'(1);
  end

  // high clocks since the stop frame rising edge, saturating at 2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= 2'd0;
    else if (ctl.gapLoad)   gapCnt <= 2'd1;
    else if (!lineIn)       gapCnt <= 2'd0;
    else if (gapCnt != 2'd2) gapCnt <= gapCnt + 2'd1;
  end

  // local interrupt register and launch request (arming wins over clearing)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ    <= 1'b0;
      pending <= 1'b0;
    end else begin
      irqQ <= irqLevel;
      if (irqLevel != irqQ)   pending <= 1'b1;
      else if (ctl.pendClear) pending <= 1'b0;
    end
  end

  // cycle mode, continuous after reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             quietMode <= 1'b0;
    else if (ctl.setQuiet) quietMode <= 1'b1;
    else if (ctl.setCont)  quietMode <= 1'b0;
  end

  always_comb begin
    sts.quiet    = quietMode;
    sts.pending  = pending;
    sts.gapOk    = lineIn && (gapCnt != 2'd0);
    sts.lastPos  = (posCnt == POS_W'(LAST_POS));
    sts.runStart = lineIn && (lowRun >= RUN_W'(START_MIN)) && (lowRun <= RUN_W'(START_MAX));
    sts.runStop2 = lineIn && (lowRun == RUN_W'(QUIET_LOW));
    sts.runStop3 = lineIn && (lowRun == RUN_W'(CONT_LOW));
  end

  // slot decode
  logic             slotValid;
  logic [CMP_W-1:0] samplePos;
  logic [CMP_W-1:0] posExt;
  logic             hitSample;
  logic             hitRecover;

  assign slotValid  = (int'(slotSel) < NUM_FRAMES);
  assign samplePos  = CMP_W'(slotSel) * CMP_W'(3) + CMP_W'(2);
  assign posExt     = CMP_W'(posCnt);
  assign hitSample  = ctl.inFrames && slotValid && (posExt == samplePos);
  assign hitRecover = ctl.inFrames && slotValid && (posExt == samplePos + CMP_W'(1));

  always_comb begin
    driveEn  = ctl.selfStart | (hitSample & ~irqQ) | hitRecover;
    driveVal = hitRecover;
  end

endmodule

// File: rtl/sirq_slave_agent.sv
module sirq_slave_agent
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 17,
  parameter int SLOT_W     = 5,
  parameter int START_MIN  = 4,
  parameter int START_MAX  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  logic              irqLevel,
  input  logic [SLOT_W-1:0] slotSel,
  output logic              driveEn,
  output logic              driveVal
);

  ctlStrobe_t ctl;
  dpStatus_t  sts;

  sirq_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .sts  (sts),
    .ctl  (ctl)
  );

  sirq_datapath #(
    .NUM_FRAMES (NUM_FRAMES),
    .SLOT_W     (SLOT_W),
    .START_MIN  (START_MIN),
    .START_MAX  (START_MAX)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .irqLevel (irqLevel),
    .slotSel  (slotSel),
    .ctl      (ctl),
    .sts      (sts),
    .driveEn  (driveEn),
    .driveVal (driveVal)
  );

endmodule

// File: rtl/sirq_slave_checker.sv
module sirq_slave_checker (
  input logic clk,
  input logic rstN,
  input logic lineIn,
  input logic irqLevel,
  input logic driveEn,
  input logic driveVal,
  input logic inFrames,
  input logic selfStart,
  input logic quietMode
);

  // R1: line released during reset
  a_r1_released_in_reset: assert property (@(posedge clk)
    !rstN |-> !driveEn);

  // R4: a frame low drive reflects a deasserted interrupt one edge earlier
  a_r4_low_means_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    (inFrames && driveEn && !driveVal) |-> !$past(irqLevel));

  // R5: low drives last one clock
  a_r5_low_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && !driveVal) |=> !(driveEn && !driveVal));

  // R5: recovery high lasts one clock
  a_r5_high_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && driveVal) |=> !(driveEn && driveVal));

  // R7: a launch only follows a high line sample
  a_r7_launch_needs_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selfStart) |-> $past(lineIn));

  // R8: no launch in continuous mode
  a_r8_no_launch_continuous: assert property (@(posedge clk) disable iff (!rstN)
    selfStart |-> quietMode);

endmodule

bind sirq_slave_agent sirq_slave_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .lineIn    (lineIn),
  .irqLevel  (irqLevel),
  .driveEn   (driveEn),
  .driveVal  (driveVal),
  .inFrames  (ctl.inFrames),
  .selfStart (ctl.selfStart),
  .quietMode (sts.quiet)
);

// File: tb/sirq_slave_agent_tb.sv
`timescale 1ns/1ps
module sirq_slave_agent_tb_top;

  localparam int NUM_FRAMES = 17;
  localparam int SLOT_W     = 5;
  localparam int LAST_POS   = 3 * NUM_FRAMES + 1;

  typedef struct packed {
    logic [4:0] slot;
    logic       irq;
    logic [3:0] startLen;
    logic [1:0] stopW;
    logic       expStart;
    logic       expLaunch;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{5'd13, 1'b0, 4'd4, 2'd2, 1'b1, 1'b1},
    '{5'd13, 1'b1, 4'd8, 2'd3, 1'b1, 1'b0},
    '{5'd0,  1'b0, 4'd6, 2'd3, 1'b1, 1'b0},
    '{5'd16, 1'b0, 4'd5, 2'd2, 1'b1, 1'b1},
    '{5'd20, 1'b0, 4'd4, 2'd3, 1'b1, 1'b0},
    '{5'd5,  1'b1, 4'd3, 2'd3, 1'b0, 1'b0},
    '{5'd5,  1'b0, 4'd9, 2'd3, 1'b0, 1'b0},
    '{5'd7,  1'b1, 4'd7, 2'd2, 1'b1, 1'b1},
    '{5'd2,  1'b0, 4'd4, 2'd3, 1'b1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              hostLow;
  logic              irqLevel;
  logic [SLOT_W-1:0] slotSel;
  logic              driveEn;
  logic              driveVal;
  logic              lineW;
  logic              obsEn;
  logic              obsVal;
  int                checks = 0;
  int                errors = 0;

  always #4 clk = ~clk;

  // wired line: agent drive wins, else host low, else pull-up
  assign lineW = driveEn ? driveVal : !hostLow;

  sirq_slave_agent #(
    .NUM_FRAMES (NUM_FRAMES),
    .SLOT_W     (SLOT_W)
  ) dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineW),
    .irqLevel (irqLevel),
    .slotSel  (slotSel),
    .driveEn  (driveEn),
    .driveVal (driveVal)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one bus clock: observe agent drive, set host drive for this clock
  task automatic cyc(input bit hl);
    @(negedge clk);
    obsEn   = driveEn;
    obsVal  = driveVal;
    hostLow = hl;
  endtask

  function automatic int code(input bit en, input bit val);
    return en ? (val ? 3 : 2) : 0;
  endfunction

  task automatic runFrames(input int startLen, input bit irqA, input bit atPos0,
                           input int slot, input string tag);
    int firstBad = -1;
    int actC = 0;
    int expC = 0;
    for (int i = 0; i < startLen; i++) begin
      cyc(1'b1);
      if (i == 0 && !atPos0) irqLevel = irqA;
    end
    for (int p = 0; p <= LAST_POS; p++) begin
      int ec = 0;
      int ac;
      cyc(1'b0);
      if (p == 0 && atPos0) irqLevel = irqA;
      if (slot < NUM_FRAMES && p == 3 * slot + 2 && !irqA) ec = 2;
      if (slot < NUM_FRAMES && p == 3 * slot + 3) ec = 3;
      ac = code(obsEn, obsVal);
      if (ac != ec && firstBad < 0) begin
        firstBad = p;
        actC = ac;
        expC = ec;
      end
    end
    check(firstBad < 0, tag, $sformatf("slot %0d drive code at pos %0d", slot, firstBad),
          actC, expC);
  endtask

  task automatic watchStop(input int lowW, input bit expLaunch, input string tag);
    int firstBad = -1;
    int actC = 0;
    int expC = 0;
    for (int i = 0; i < lowW; i++) cyc(1'b1);
    for (int k = 0; k < 6; k++) begin
      int ec;
      int ac;
      cyc(1'b0);
      ec = (expLaunch && k == 2) ? 2 : 0;
      ac = code(obsEn, obsVal);
      if (ac != ec && firstBad < 0) begin
        firstBad = k;
        actC = ac;
        expC = ec;
      end
    end
    check(firstBad < 0, tag, $sformatf("stop width %0d, clock %0d after rise", lowW, firstBad),
          actC, expC);
  endtask

  task automatic noDrive(input int n, input string tag, input string what);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0);
      if (obsEn) bad++;
    end
    check(bad == 0, tag, what, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    hostLow  = 1'b0;
    irqLevel = 1'b0;
    slotSel  = 5'd13;

    // R1: released while in reset, even with host activity
    for (int i = 0; i < 4; i++) begin
      cyc(i[0]);
      check(!obsEn, "R1", "drive enable during reset", int'(obsEn), 0);
    end
    cyc(1'b0);
    rstN = 1'b1;
    cyc(1'b0);

    // R1 R8: continuous after reset, an interrupt change launches nothing
    irqLevel = 1'b1;
    noDrive(12, "R1 R8", "drive cycles after reset with irq change");

    // table of vectors
    for (int v = 0; v < NVEC; v++) begin
      slotSel = VECS[v].slot;
      if (VECS[v].expStart) begin
        runFrames(int'(VECS[v].startLen), VECS[v].irq, 1'b0, int'(VECS[v].slot), "R2 R3 R4 R5");
        cyc(1'b0);
        irqLevel = !irqLevel;
        cyc(1'b0);
        watchStop(int'(VECS[v].stopW), VECS[v].expLaunch, "R6 R7 R8");
      end else begin
        for (int i = 0; i < int'(VECS[v].startLen); i++) begin
          cyc(1'b1);
          if (i == 0) irqLevel = VECS[v].irq;
        end
        noDrive(60, "R2", $sformatf("drive cycles after low run of %0d", VECS[v].startLen));
      end
    end

    // R9 control: change during start frame is cleared at recognition
    slotSel = 5'd3;
    runFrames(6, !irqLevel, 1'b0, 3, "R3 R4");
    cyc(1'b0);
    cyc(1'b0);
    watchStop(2, 1'b0, "R9");

    // R9 collision: change on the recognition edge keeps the request
    runFrames(6, !irqLevel, 1'b1, 3, "R4 R9");
    cyc(1'b0);
    cyc(1'b0);
    watchStop(2, 1'b1, "R9");

    // R6: an out-of-range stop width is ignored, a later valid one counts
    slotSel = 5'd9;
    runFrames(4, irqLevel, 1'b0, 9, "R3 R4");
    cyc(1'b0);
    irqLevel = !irqLevel;
    cyc(1'b0);
    watchStop(4, 1'b0, "R6");
    watchStop(2, 1'b1, "R6 R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule